// File: doc/BRIEF.md
# SD Card Clock Generator

This block derives the card clock for an SD/MMC host from the system clock. An N-bit divider value sets the half period. Each phase of the card clock lasts N+1 system cycles, so the card clock runs at f_sys / (2·(N+1)). Software is expected to choose N as the smallest value that keeps the card clock at or below the requested rate. That is ceil(f_sys / (2·f_card)) − 1, limited to 255. A control word carries an output inversion bit, a stop bit and a small sample-adjust field. The adjust field is only held and presented at a port for the analog delay logic.

Besides the clock, the generator drives two one-cycle strobes that line up with the card clock edges. The sample strobe marks a rising edge and is used by the command and data engines to capture input. The launch strobe marks a falling edge and is used to drive output. Starting, stopping, divider changes and inversion are all sequenced so that no card clock phase is ever shorter than N+1 system cycles.

Internally, the clock is held as a phase bit. Phase 0 is the rest phase; phase 1 is the active phase. The card clock equals the phase bit XOR the effective inversion. The generator stops only at the end of a complete rest phase, so the clock stands at its rest level while stopped.

Top module: `sdclk_gen`

## Requirements
- R1: While running with divider value N (0 to 255), every high phase and every low phase of `card_clk` lasts exactly N+1 system clock cycles, so the period is 2·(N+1) cycles; N=0 toggles every cycle.
- R2: Reset state:
  - the divider register is 255;
  - the control word has stop=1, invert=0 and adjust=1;
  - `card_clk` is 0 and both strobes are 0;
  - the clock stays stopped until software clears the stop bit.
- R3: Control bit 4 inverts the card clock, so the stopped (rest) level becomes 1. The bit is taken up only while the generator is stopped; a change made while it runs leaves the output phases unbroken until the next stop.
- R4: A divider write is captured one cycle after the write strobe. It takes effect at the next start of an active phase (rising edge of `card_clk` when not inverted). The active phase and rest phase in progress keep the old length.
- R5: Control bit 5 stops the clock. The generator runs on until a complete rest phase ends, then holds `card_clk` at the rest level with no strobes. No phase shorter than N+1 cycles is produced.
- R6: After the stop bit is cleared while stopped, the first edge out of the rest level appears on the (N+2)-th system clock edge after the edge that captures the control write.
- R7: `sample_stb` is 1 exactly in the first cycle in which `card_clk` is 1 after a rising edge. `launch_stb` is 1 exactly in the first cycle in which `card_clk` is 0 after a falling edge. Both strobes follow the inverted output when bit 4 is in effect, and the two are never 1 together.
- R8: Control bits [3:0] appear on `adj_out` in the cycle after the control write edge. Control bits 7 and 6 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_wr | input | 1 | Write strobe for the divider value |
| div_wdata | input | DIV_W (8) | Divider value N |
| ctl_wr | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 8 | Control word: [3:0] adjust, [4] invert, [5] stop, [7:6] ignored |
| card_clk | output | 1 | Card clock |
| sample_stb | output | 1 | One-cycle strobe on each card clock rising edge |
| launch_stb | output | 1 | One-cycle strobe on each card clock falling edge |
| adj_out | output | ADJ_W (4) | Held sample-adjust value |

## Verification
A divider write and a stop request can both land on the same rest-to-active boundary. In that case the stop must win, and the new divider value must wait for the next start.

The bench provokes this in two steps:
- It writes the stop bit in the first cycle of an active phase and confirms that the clock completes exactly one active phase and one rest phase of the old length, then rests.
- It writes a new divider in that same first cycle and confirms that the running phases keep their old length until the next rising boundary.

A behavioural reference model, compared on every cycle, judges all edges, strobes and rest levels. This covers the cycle where an inversion change meets a running clock.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

   // Control word layout
   localparam int CTL_W       = 8;
   localparam int ADJ_FIELD_W = 4;
   localparam int INV_POS     = 4;
   localparam int STOP_POS    = 5;

   typedef struct packed {
      logic                   stop;
      logic                   inv;
      logic [ADJ_FIELD_W-1:0] adj;
   } clk_ctl_t;

   localparam clk_ctl_t CTL_RESET = '{stop: 1'b1, inv: 1'b0, adj: 4'd1};

endpackage

// File: rtl/sdclk_cfg.sv
module sdclk_cfg
   import sdclk_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             div_wr,
   input  logic [DIV_W-1:0] div_wdata,
   input  logic             ctl_wr,
   input  logic [CTL_W-1:0] ctl_wdata,
   output logic [DIV_W-1:0] div_q,
   output clk_ctl_t         ctl_q
);

   localparam int HI_W = CTL_W - STOP_POS - 1;

   logic [HI_W-1:0] unused_ctl_hi;
   assign unused_ctl_hi = ctl_wdata[CTL_W-1:STOP_POS+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '1;
      end else if (div_wr) begin
         div_q <= div_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= CTL_RESET;
      end else if (ctl_wr) begin
         ctl_q.stop <= ctl_wdata[STOP_POS];
         ctl_q.inv  <= ctl_wdata[INV_POS];
         ctl_q.adj  <= ctl_wdata[ADJ_FIELD_W-1:0];
      end
   end

   AST_DIV_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      div_wr |=> div_q == $past(div_wdata));  // R4

endmodule

// File: rtl/sdclk_div.sv
module sdclk_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_cfg,
   input  logic             stop_req,
   input  logic             inv_cfg,
   output logic             phase,
   output logic             inv_act,
   output logic             rise_q,
   output logic             fall_q
);

   logic             run;
   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] div_act;
   logic             half_done;

   assign half_done = (cnt == div_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run     <= 1'b0;
         phase   <= 1'b0;
         cnt     <= '0;
         div_act <= '1;
         inv_act <= 1'b0;
         rise_q  <= 1'b0;
         fall_q  <= 1'b0;
      end else begin
         rise_q <= 1'b0;
         fall_q <= 1'b0;
         if (!run) begin
            // stopped: hold at rest, follow the configuration
            cnt     <= '0;
            phase   <= 1'b0;
            div_act <= div_cfg;
            inv_act <= inv_cfg;
            run     <= !stop_req;
         end else if (half_done) begin
            cnt <= '0;
            if (!phase) begin
               // end of a rest phase: stop here or start an active phase
               if (stop_req) begin
                  run <= 1'b0;
               end else begin
                  phase   <= 1'b1;
                  rise_q  <= 1'b1;
                  div_act <= div_cfg;
               end
            end else begin
               phase  <= 1'b0;
               fall_q <= 1'b1;
            end
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   AST_HALF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= div_act);  // R1

   AST_STOP_AT_REST: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run) |-> !phase && !$past(phase));  // R5

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !rise_q && !fall_q);  // R5

   AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      phase && $past(phase) |-> $stable(div_act));  // R4

   AST_INV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      run && $past(run) |-> $stable(inv_act));  // R3

endmodule

// File: rtl/sdclk_edge.sv
module sdclk_edge #(
   parameter int OUT_REG = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic phase,
   input  logic inv_act,
   input  logic rise_q,
   input  logic fall_q,
   output logic card_clk,
   output logic sample_stb,
   output logic launch_stb
);

   logic clk_c;
   logic smp_c;
   logic lch_c;

   assign clk_c = phase ^ inv_act;
   assign smp_c = inv_act ? fall_q : rise_q;
   assign lch_c = inv_act ? rise_q : fall_q;

   generate
      if (OUT_REG != 0) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               card_clk   <= 1'b0;
               sample_stb <= 1'b0;
               launch_stb <= 1'b0;
            end else begin
               card_clk   <= clk_c;
               sample_stb <= smp_c;
               launch_stb <= lch_c;
            end
         end
      end else begin : g_comb
         assign card_clk   = clk_c;
         assign sample_stb = smp_c;
         assign launch_stb = lch_c;
      end
   endgenerate

   AST_SAMPLE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |-> card_clk && !$past(card_clk));  // R7

   AST_LAUNCH_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      launch_stb |-> !card_clk && $past(card_clk));  // R7

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(sample_stb && launch_stb));  // R7

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
   import sdclk_pkg::*;
#(
   parameter int DIV_W   = 8,
   parameter int ADJ_W   = 4,
   parameter int OUT_REG = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             div_wr,
   input  logic [DIV_W-1:0] div_wdata,
   input  logic             ctl_wr,
   input  logic [CTL_W-1:0] ctl_wdata,
   output logic             card_clk,
   output logic             sample_stb,
   output logic             launch_stb,
   output logic [ADJ_W-1:0] adj_out
);

   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("sdclk_gen: DIV_W must lie in 1..16");
      end
      if (ADJ_W < 1 || ADJ_W > ADJ_FIELD_W) begin : g_bad_adj
         $error("sdclk_gen: ADJ_W must lie in 1..4");
      end
      if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_out
         $error("sdclk_gen: OUT_REG must be 0 or 1");
      end
   endgenerate

   logic [DIV_W-1:0] div_q;
   clk_ctl_t         ctl_q;
   logic             phase;
   logic             inv_act;
   logic             rise_q;
   logic             fall_q;

   sdclk_cfg #(.DIV_W(DIV_W)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .div_wr    (div_wr),
      .div_wdata (div_wdata),
      .ctl_wr    (ctl_wr),
      .ctl_wdata (ctl_wdata),
      .div_q     (div_q),
      .ctl_q     (ctl_q)
   );

   sdclk_div #(.DIV_W(DIV_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .div_cfg  (div_q),
      .stop_req (ctl_q.stop),
      .inv_cfg  (ctl_q.inv),
      .phase    (phase),
      .inv_act  (inv_act),
      .rise_q   (rise_q),
      .fall_q   (fall_q)
   );

   sdclk_edge #(.OUT_REG(OUT_REG)) u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .phase      (phase),
      .inv_act    (inv_act),
      .rise_q     (rise_q),
      .fall_q     (fall_q),
      .card_clk   (card_clk),
      .sample_stb (sample_stb),
      .launch_stb (launch_stb)
   );

   assign adj_out = ctl_q.adj[ADJ_W-1:0];

   generate
      if (ADJ_W < ADJ_FIELD_W) begin : g_adj_trim
         logic [ADJ_FIELD_W-ADJ_W-1:0] unused_adj_hi;
         assign unused_adj_hi = ctl_q.adj[ADJ_FIELD_W-1:ADJ_W];
      end
   endgenerate

   AST_ADJ_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> adj_out == $past(ctl_wdata[ADJ_W-1:0]));  // R8

endmodule

// File: tb/tb_sdclk_gen.sv
`timescale 1ns/1ps
module tb_sdclk_gen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       div_wr = 1'b0;
   logic [7:0] div_wdata = 8'd0;
   logic       ctl_wr = 1'b0;
   logic [7:0] ctl_wdata = 8'd0;
   logic       card_clk;
   logic       sample_stb;
   logic       launch_stb;
   logic [3:0] adj_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit cmp_en = 1'b0;
   int cyc = 0;

   always #10 clk = ~clk;  // 50 MHz

   sdclk_gen dut (
      .clk(clk), .rst_n(rst_n),
      .div_wr(div_wr), .div_wdata(div_wdata),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .card_clk(card_clk), .sample_stb(sample_stb),
      .launch_stb(launch_stb), .adj_out(adj_out)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // ---------------- reference model (countdown based) ----------------
   int m_div, m_adj, m_inv, m_stop;
   int m_run, m_lvl, m_left, m_hdiv, m_inva, m_rise, m_fall;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_div = 255; m_adj = 1; m_inv = 0; m_stop = 1;
         m_run = 0; m_lvl = 0; m_left = 0; m_hdiv = 255; m_inva = 0;
         m_rise = 0; m_fall = 0;
      end else begin
         m_rise = 0; m_fall = 0;
         if (m_run == 0) begin
            m_lvl = 0; m_hdiv = m_div; m_left = m_div; m_inva = m_inv;
            if (m_stop == 0) m_run = 1;
         end else if (m_left == 0) begin
            if (m_lvl == 0) begin
               if (m_stop != 0) m_run = 0;
               else begin m_lvl = 1; m_rise = 1; m_hdiv = m_div; end
            end else begin
               m_lvl = 0; m_fall = 1;
            end
            m_left = m_hdiv;
         end else begin
            m_left = m_left - 1;
         end
         if (div_wr) m_div = div_wdata;
         if (ctl_wr) begin
            m_adj = ctl_wdata[3:0]; m_inv = ctl_wdata[4]; m_stop = ctl_wdata[5];
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && cmp_en && !done) begin
         chk(card_clk == ((m_lvl ^ m_inva) != 0), "R1 R3 R5 card_clk vs model",
             card_clk, m_lvl ^ m_inva);
         chk(sample_stb == ((m_inva != 0) ? (m_fall != 0) : (m_rise != 0)),
             "R7 sample_stb vs model", sample_stb, (m_inva != 0) ? m_fall : m_rise);
         chk(launch_stb == ((m_inva != 0) ? (m_rise != 0) : (m_fall != 0)),
             "R7 launch_stb vs model", launch_stb, (m_inva != 0) ? m_rise : m_fall);
         chk(adj_out == m_adj[3:0], "R8 adj_out vs model", adj_out, m_adj);
      end
   end

   // ---------------- phase length tracker ----------------
   int hq[$];
   int lvl_last = 0;
   int run_len = 0;

   always @(negedge clk) begin
      if (!rst_n) begin
         lvl_last = 0; run_len = 0;
      end else if (int'(card_clk) == lvl_last) begin
         run_len++;
      end else begin
         hq.push_back(run_len);
         lvl_last = int'(card_clk);
         run_len = 1;
      end
   end

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic step();
      @(negedge clk);
      #2;
   endtask

   task automatic write_div(input logic [7:0] v);
      div_wr = 1'b1; div_wdata = v;
      step();
      div_wr = 1'b0;
   endtask

   task automatic write_ctl(input logic [7:0] v);
      ctl_wr = 1'b1; ctl_wdata = v;
      step();
      ctl_wr = 1'b0;
   endtask

   task automatic wait_phases(input int n);
      int g = 0;
      while (hq.size() < n && g < 5000) begin step(); g++; end
   endtask

   task automatic wait_sample();
      int g = 0;
      while (!sample_stb && g < 2000) begin step(); g++; end
   endtask

   task automatic start_latency(input int n, input string tag);
      int k = 0;
      write_ctl(8'h01);
      while (!card_clk && k < 1000) begin step(); k++; end
      chk(k == n + 2, tag, k, n + 2);
   endtask

   initial begin
      step();
      step();
      // R2 reset state
      chk(card_clk == 1'b0, "R2 reset card_clk", card_clk, 0);
      chk(sample_stb == 1'b0 && launch_stb == 1'b0, "R2 reset strobes",
          sample_stb | launch_stb, 0);
      chk(adj_out == 4'd1, "R2 reset adjust", adj_out, 1);
      rst_n = 1'b1;
      cmp_en = 1'b1;
      repeat (20) step();
      chk(card_clk == 1'b0 && hq.size() == 0, "R2 stays stopped after reset",
          hq.size(), 0);

      // R6 / R2: start with default divider 255
      hq.delete();
      start_latency(255, "R6 start latency N=255");
      wait_phases(2);
      chk(hq.size() >= 2 && hq[1] == 256, "R2 R1 default high phase",
          hq.size() >= 2 ? hq[1] : -1, 256);

      // R5: stop while running, no runt phases
      write_ctl(8'h21);
      repeat (700) step();
      chk(card_clk == 1'b0, "R5 stopped at rest level", card_clk, 0);
      for (int i = 1; i < hq.size(); i++)
         chk(hq[i] == 256, "R5 no short phase at stop", hq[i], 256);

      // R1 fastest rate
      write_div(8'd0);
      start_latency(0, "R6 start latency N=0");
      repeat (6) step();
      hq.delete();
      wait_phases(6);
      for (int i = 0; i < 6; i++)
         chk(hq[i] == 1, "R1 N=0 phase length", hq[i], 1);

      // R4 divider change mid-active phase
      write_div(8'd3);
      repeat (30) step();
      wait_sample();
      hq.delete();
      write_div(8'd1);
      wait_phases(4);
      chk(hq[0] == 4, "R4 current high keeps old length", hq[0], 4);
      chk(hq[1] == 4, "R4 current low keeps old length", hq[1], 4);
      chk(hq[2] == 2, "R4 new length from next rising", hq[2], 2);
      chk(hq[3] == 2, "R4 new low length", hq[3], 2);

      // R5 stop written at start of an active phase (N=1)
      repeat (5) step();
      wait_sample();
      hq.delete();
      write_ctl(8'h21);
      repeat (40) step();
      chk(hq.size() == 1, "R5 exactly one phase after stop", hq.size(), 1);
      chk(hq.size() >= 1 && hq[0] == 2, "R5 final high full length",
          hq.size() >= 1 ? hq[0] : -1, 2);
      chk(card_clk == 1'b0, "R5 rests low", card_clk, 0);

      // R3 inversion
      write_ctl(8'h31);
      step();
      chk(card_clk == 1'b1, "R3 inverted rest level", card_clk, 1);
      write_div(8'd2);
      write_ctl(8'h11);
      for (int i = 0; i < 40; i++) begin
         step();
         if (sample_stb) chk(card_clk == 1'b1, "R7 sample at inverted rise", card_clk, 1);
         if (launch_stb) chk(card_clk == 1'b0, "R7 launch at inverted fall", card_clk, 0);
         chk(!(sample_stb && launch_stb), "R7 strobes exclusive", 1, 0);
      end
      hq.delete();
      write_ctl(8'h01);
      repeat (24) step();
      chk(hq.size() >= 4, "R3 clock keeps running", hq.size(), 4);
      for (int i = 0; i < hq.size(); i++)
         chk(hq[i] == 3, "R3 no broken phase on invert change", hq[i], 3);

      // R8 adjust field, upper bits ignored
      write_ctl(8'hEF);
      chk(adj_out == 4'hF, "R8 adjust loaded", adj_out, 15);
      repeat (30) step();
      begin
         int s = 0;
         for (int i = 0; i < 20; i++) begin
            step();
            if (sample_stb || launch_stb) s++;
         end
         chk(s == 0, "R8 bits 7:6 do not start clock", s, 0);
      end
      write_ctl(8'hC0);
      chk(adj_out == 4'h0, "R8 adjust cleared", adj_out, 0);
      repeat (20) step();

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule